// File: doc/BRIEF.md
# Programmable Divider and Interval Timer

This block is a timer peripheral for an 8-bit processor bus. A free-running divider byte advances once per fixed number of input dots. A programmable counter advances at one of four selectable dot rates. When the counter passes its top value, it reloads from a modulo byte and pulses an interrupt request for one cycle. A chosen divider bit also provides a secondary tick: each time an increment drops that bit from one to zero, the block emits a one-cycle strobe that can drive an audio frame sequencer.

Software reaches four byte registers through a simple read/write port. Each dot is one clock cycle with `dot_tick` high. Read data is registered and appears on the cycle after the read strobe.

Top module: `divtimer`

## Requirements
- R1: After reset, the divider, counter, modulo and control registers are zero and both pulse outputs are low. A read of the control register then returns 0xF8.
- R2: The divider byte increments by one after every 256 dots and wraps from 255 to 0.
- R3: Any write to offset 0 clears the divider to zero, whatever the data. Such a write overrides an increment in the same cycle and never produces a secondary tick.
- R4: `seq_tick` is high for exactly one cycle after an increment that takes divider bit 4 from 1 to 0. It rises in the same cycle that the new divider value becomes visible.
- R5: The counter and its rate accumulator advance only while control bit 2 is 1. While that bit is 0 they hold their values.
- R6: Control bits [1:0] set the counter period in dots: 0 gives 1024, 1 gives 16, 2 gives 64 and 3 gives 256. The dot accumulator keeps the residue past each period, and it is not cleared when the rate changes.
- R7: When a period elapses and the counter is below 255, the counter increments by one.
- R8: When a period elapses with the counter at 255, the counter loads the modulo value and `irq_timer` is high for one cycle. The pulse appears in the same cycle as the reloaded value.
- R9: A write to offset 1 sets the counter and takes priority over a step or an overflow in the same cycle, so that cycle raises no interrupt. A write to offset 2 in the same cycle as an overflow does not change the reload, which uses the previous modulo value.
- R10: The register offsets are: 0 divider, 1 counter, 2 modulo, 3 control. `bus_rdata` is updated on the cycle after `bus_rd` and shows the register values from before any write in that same cycle. Control reads return 1 in bits [7:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_tick | input | 1 | One dot elapses in each cycle this is high |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_timer | output | 1 | One-cycle counter overflow interrupt request |
| seq_tick | output | 1 | One-cycle strobe when divider bit 4 falls |

## Verification
The assertions assume three things about the inputs:
- `bus_wr` and `bus_rd` stay low while reset is applied.
- `dot_tick` carries at most one dot per cycle.
- Every input changes only between clock edges.

The stimulus drives all inputs on the falling clock edge and holds the strobes low during reset. Random traffic keeps writes sparse and leans counter writes toward values near 255, so that overflows, rate changes with a large residue, and same-cycle write/overflow collisions all occur.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;

  typedef enum logic [1:0] {
    OFS_DIV = 2'd0,
    OFS_CNT = 2'd1,
    OFS_MOD = 2'd2,
    OFS_CTL = 2'd3
  } reg_ofs_e;

  localparam int CTL_W      = 3;
  localparam int CTL_RUN    = 2;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/divtimer_divider.sv
module divtimer_divider #(
  parameter int DIV_DOTS = 256,
  parameter int DATA_W   = 8,
  parameter int TAP      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  output logic [DATA_W-1:0] div_o,
  output logic              aud_tick_o
);

  localparam int PW = $clog2(DIV_DOTS) + 1;
  localparam logic [PW-1:0] LAST = PW'(DIV_DOTS - 1);

  logic [PW-1:0]     pre_q;
  logic              inc;
  logic [DATA_W-1:0] div_nxt;

  assign inc     = tick && (pre_q == LAST);
  assign div_nxt = div_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= inc ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o      <= '0;
      aud_tick_o <= 1'b0;
    end else if (clr) begin
      div_o      <= '0;
      aud_tick_o <= 1'b0;
    end else if (inc) begin
      div_o      <= div_nxt;
      aud_tick_o <= div_o[TAP] && !div_nxt[TAP];
    end else begin
      aud_tick_o <= 1'b0;
    end
  end

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (div_o == '0) && !aud_tick_o); // R3

  AST_AUD_EDGE: assert property (@(posedge clk) disable iff (rst)
    aud_tick_o |-> !div_o[TAP] && $past(div_o[TAP])); // R4

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && (div_o != $past(div_o))) |-> (div_o == $past(div_o) + 1'b1)); // R2

endmodule

// File: rtl/divtimer_rate.sv
module divtimer_rate #(
  parameter int SHIFT0 = 10,
  parameter int SHIFT1 = 4,
  parameter int SHIFT2 = 6,
  parameter int SHIFT3 = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       step_o
);

  localparam int MAXS  = divtimer_pkg::max4(SHIFT0, SHIFT1, SHIFT2, SHIFT3);
  localparam int ACC_W = MAXS + 1;
  localparam int NSEL  = 4;
  localparam int SHIFTS [NSEL] = '{SHIFT0, SHIFT1, SHIFT2, SHIFT3};

  logic [ACC_W-1:0] per_tab [NSEL];
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_inc;
  logic [ACC_W-1:0] period;

  for (genvar g = 0; g < NSEL; g++) begin : g_per
    assign per_tab[g] = ACC_W'(1) << SHIFTS[g];
  end

  assign period  = per_tab[sel];
  assign acc_inc = acc_q + 1'b1;
  assign step_o  = en && tick && (acc_inc >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en && tick) begin
      acc_q <= step_o ? acc_inc - period : acc_inc;
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    acc_q < (ACC_W'(1) << MAXS)); // R6

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q)); // R5

endmodule

// File: rtl/divtimer_counter.sv
module divtimer_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wr_cnt,
  input  logic              wr_mod,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              irq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      mod_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_mod) mod_o <= wdata;
      if (wr_cnt) begin
        cnt_o <= wdata;
      end else if (step) begin
        if (cnt_o == '1) begin
          cnt_o <= mod_o;
          irq_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (cnt_o == $past(mod_o)) && ($past(cnt_o) == '1)); // R8

  AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
    ($past(step) && !$past(wr_cnt) && ($past(cnt_o) != '1)) |->
      (cnt_o == $past(cnt_o) + 1'b1) && !irq_o); // R7

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_cnt) |-> (cnt_o == $past(wdata)) && !irq_o); // R9

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(step) && !$past(wr_cnt)) |-> $stable(cnt_o)); // R5

endmodule

// File: rtl/divtimer.sv
module divtimer #(
  parameter int DATA_W   = 8,
  parameter int DIV_DOTS = 256,
  parameter int AUD_TAP  = 4,
  parameter int SHIFT0   = 10,
  parameter int SHIFT1   = 4,
  parameter int SHIFT2   = 6,
  parameter int SHIFT3   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_tick,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_timer,
  output logic              seq_tick
);

  import divtimer_pkg::*;

  localparam int PAD_W = DATA_W - CTL_W;

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] div_v, cnt_v, mod_v;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_div, wr_cnt, wr_mod, wr_ctl;
  logic              step;

  assign wr_div = bus_wr && (bus_addr == OFS_DIV);
  assign wr_cnt = bus_wr && (bus_addr == OFS_CNT);
  assign wr_mod = bus_wr && (bus_addr == OFS_MOD);
  assign wr_ctl = bus_wr && (bus_addr == OFS_CTL);

  divtimer_divider #(.DIV_DOTS(DIV_DOTS), .DATA_W(DATA_W), .TAP(AUD_TAP)) u_div (
    .clk(clk), .rst(rst), .tick(dot_tick), .clr(wr_div),
    .div_o(div_v), .aud_tick_o(seq_tick)
  );

  divtimer_rate #(.SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2), .SHIFT3(SHIFT3)) u_rate (
    .clk(clk), .rst(rst), .tick(dot_tick), .en(ctl_q[CTL_RUN]),
    .sel(ctl_q[1:0]), .step_o(step)
  );

  divtimer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .wr_cnt(wr_cnt), .wr_mod(wr_mod),
    .wdata(bus_wdata), .cnt_o(cnt_v), .mod_o(mod_v), .irq_o(irq_timer)
  );

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DIV: rd_mux = div_v;
      OFS_CNT: rd_mux = cnt_v;
      OFS_MOD: rd_mux = mod_v;
      default: rd_mux = {{PAD_W{1'b1}}, ctl_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_CTL_PAD: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && ($past(bus_addr) == OFS_CTL)) |->
      (bus_rdata[DATA_W-1:CTL_W] == '1)); // R10

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ctl) |-> (ctl_q == $past(bus_wdata[CTL_W-1:0]))); // R10

endmodule

// File: tb/test_divtimer.sv
module test_divtimer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dot_tick = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_timer, seq_tick;

  int checks = 0;
  int fails  = 0;

  int       m_dacc, m_tacc;
  bit [7:0] m_div, m_cnt, m_mod;
  bit [2:0] m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  divtimer i_divtimer (
    .clk(clk), .rst(rst), .dot_tick(dot_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_timer(irq_timer), .seq_tick(seq_tick)
  );

  function automatic int period(bit [1:0] s);
    case (s)
      2'd0: return 1024;
      2'd1: return 16;
      2'd2: return 64;
      default: return 256;
    endcase
  endfunction

  function automatic bit [7:0] regval(bit [1:0] a);
    case (a)
      2'd0: return m_div;
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return {5'b11111, m_ctl};
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit w, bit [1:0] a, bit [7:0] d, bit r, string tag);
    bit [7:0] e_rd, nd, old_mod;
    bit e_aud, e_irq, inc, fire;
    int per;
    @(negedge clk);
    dot_tick = t; bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r;
    e_rd = regval(a);
    e_aud = 0; e_irq = 0; inc = 0; fire = 0;
    if (t) begin
      if (m_dacc == 255) begin m_dacc = 0; inc = 1; end
      else m_dacc++;
    end
    nd = m_div + 8'd1;
    if (w && a == 2'd0) m_div = 0;
    else if (inc) begin e_aud = m_div[4] && !nd[4]; m_div = nd; end
    if (m_ctl[2] && t) begin
      per = period(m_ctl[1:0]);
      if (m_tacc + 1 >= per) begin fire = 1; m_tacc = m_tacc + 1 - per; end
      else m_tacc++;
    end
    old_mod = m_mod;
    if (w && a == 2'd2) m_mod = d;
    if (w && a == 2'd1) m_cnt = d;
    else if (fire) begin
      if (m_cnt == 8'hFF) begin m_cnt = old_mod; e_irq = 1; end
      else m_cnt++;
    end
    if (w && a == 2'd3) m_ctl = d[2:0];
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R4 seq_tick", int'(seq_tick), int'(e_aud));
    chk("R8 irq_timer", int'(irq_timer), int'(e_irq));
    if (r) chk(tag, int'(bus_rdata), int'(e_rd));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, "");
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    step(0, 1, a, d, 0, "");
  endtask

  task automatic rd(bit [1:0] a, string tag);
    step(0, 0, a, 0, 1, tag);
  endtask

  task automatic to_fire_edge();
    while (m_tacc + 1 < period(m_ctl[1:0])) step(1, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_dacc = 0; m_tacc = 0; m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    chk("R1 irq after reset", int'(irq_timer), 0);
    chk("R1 seq_tick after reset", int'(seq_tick), 0);
    rd(0, "R1 divider reset"); chk("R1 divider zero", int'(bus_rdata), 0);
    rd(1, "R1 counter reset");
    rd(2, "R1 modulo reset");
    rd(3, "R1 control reset"); chk("R1 control 0xF8", int'(bus_rdata), 'hF8);

    ticks(768);
    rd(0, "R2 divider"); chk("R2 divider after 768 dots", int'(bus_rdata), 3);
    ticks(255);
    rd(0, "R2 divider before step"); chk("R2 divider holds at 255th dot", int'(bus_rdata), 3);
    ticks(1);
    rd(0, "R2 divider stepped"); chk("R2 divider after 1024 dots", int'(bus_rdata), 4);

    wr(0, 8'hA5);
    rd(0, "R3 divider cleared"); chk("R3 clear ignores data", int'(bus_rdata), 0);
    ticks(256 * 40);
    while (m_dacc != 255 || m_div[4] != 1'b1 || m_div[3:0] != 4'hF) step(1, 0, 0, 0, 0, "");
    step(1, 1, 0, 8'h3C, 0, "");
    chk("R3 no seq_tick on clearing write", int'(seq_tick), 0);
    rd(0, "R3 clear beats increment");

    wr(1, 8'h00); wr(3, 8'h05);
    ticks(80);
    rd(1, "R6 rate 16"); chk("R6 five periods of 16", int'(bus_rdata), 5);
    wr(3, 8'h06); ticks(128);
    rd(1, "R6 rate 64");
    wr(3, 8'h07); ticks(512);
    rd(1, "R6 rate 256");
    wr(3, 8'h04); ticks(1024);
    rd(1, "R6 rate 1024");
    wr(3, 8'h01); ticks(300);
    rd(1, "R5 disabled counter holds");
    rd(3, "R10 control read");

    wr(2, 8'h40); wr(1, 8'hFE); wr(3, 8'h05);
    to_fire_edge(); step(1, 0, 0, 0, 0, "");
    rd(1, "R7 increment to 255"); chk("R7 counter at 0xFF", int'(bus_rdata), 'hFF);
    to_fire_edge(); step(1, 0, 0, 0, 0, "");
    rd(1, "R8 reload"); chk("R8 reload value", int'(bus_rdata), 'h40);

    wr(1, 8'hFF);
    to_fire_edge(); step(1, 1, 1, 8'h22, 0, "");
    chk("R9 no irq on write collision", int'(irq_timer), 0);
    rd(1, "R9 write wins"); chk("R9 written value", int'(bus_rdata), 'h22);
    wr(2, 8'h11); wr(1, 8'hFF);
    to_fire_edge(); step(1, 1, 2, 8'h99, 0, "");
    rd(1, "R9 reload uses old modulo"); chk("R9 old modulo", int'(bus_rdata), 'h11);
    rd(2, "R10 modulo updated");

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 20000; i++) begin
      bit t, w, r;
      bit [1:0] a;
      bit [7:0] d;
      string tag;
      t = ($urandom % 4) != 0;
      w = ($urandom % 40) == 0;
      r = ($urandom % 5) == 0;
      a = 2'($urandom);
      d = 8'($urandom);
      if (w && a == 2'd1 && ($urandom % 2)) d = 8'hF0 | d[3:0];
      case (a)
        2'd0: tag = "R2 random divider read";
        2'd1: tag = "R7 random counter read";
        2'd2: tag = "R10 random modulo read";
        default: tag = "R10 random control read";
      endcase
      step(t, w, a, d, r, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule